// File: doc/BRIEF.md
# APB Memory Completer with Wait-State and Error Injection

This block answers APB transfers from a small on-chip word memory. A transfer is decoded when the select line is high and the enable line is low at a clock edge. The write/read line seen in that same setup cycle decides whether the transfer stores `pwdata` or returns a word on `prdata`. Each memory entry has a valid flag. An entry that has never been written since reset reads back as the parameter `DEFAULT_VAL`.

Three side inputs shape each transfer:

- `cfgWait` sets how many access-phase cycles the block holds `pready` low before it completes.
- `cfgErr` sets whether `pslverr` is raised in the completing cycle.
- `cfgIdleReady` sets the level that `pready` shows whenever no transfer is being served.

Both `cfgWait` and `cfgErr` are sampled once, in the setup cycle. This lets a bench or a system model slow a transfer down or make it fail, one transfer at a time. An asynchronous active-low reset returns the outputs to idle at once and forgets every stored word.

Top module: `apb_wait_mem`

## Requirements
- R1: A transfer begins on a rising clock edge where `psel`=1 and `penable`=0. The value of `pwrite` at that edge selects a write (1) or a read (0).
- R2: A write stores `pwdata` at the edge that ends the transfer, into the entry indexed by `paddr[ADDR_BITS+1:2]` (`ADDR_BITS` = log2 of `DEPTH`). All other address bits are ignored, so addresses that differ only in those bits share one entry.
- R3: A read returns the stored word when the indexed entry has been written since reset, and `DEFAULT_VAL` otherwise.
- R4: With a sampled wait count N, `pready` is 0 for the first N cycles of the access phase and 1 in cycle N+1, which is the completing cycle. With N=0, the first access cycle completes.
- R5: `cfgWait` and `cfgErr` are sampled at the setup edge only. Changing them during the access phase does not alter that transfer's length or error response.
- R6: In the completing cycle, `pslverr` equals the sampled error flag. `prdata` carries the read word for a read and is 0 for a write.
- R7: In the cycle after completion, `pready` equals `cfgIdleReady`, and `pslverr` and `prdata` are 0.
- R8: Outside a transfer, `prdata`=0, `pslverr`=0 and `pready` follows `cfgIdleReady`.
- R9: Driving `rstN` low immediately forces `prdata` and `pslverr` to 0 and `pready` to `cfgIdleReady`, even in the middle of a completing cycle. After reset, every entry reads as `DEFAULT_VAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 32 | Byte address |
| pwdata | input | 32 | Write data |
| cfgWait | input | WAIT_BITS | Wait cycles for the next transfer |
| cfgErr | input | 1 | Error response for the next transfer |
| cfgIdleReady | input | 1 | Idle level of `pready` |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer completion |
| pslverr | output | 1 | Error response |

## Verification
The hardest case to reach from the ports is a reset that lands inside a completing cycle, while `pready`, `pslverr` and a non-zero `prdata` are all active. The bench stretches a read of a written entry with wait states and an error flag, and sets the idle level to 0 so that the idle level and the completing level differ. It then drops `rstN` between clock edges once `pready` has risen, and checks the outputs before the next edge. A second subtle case is a change to the side inputs during the access phase. The bench inverts them right after every setup edge, so every transfer also tests that they were sampled only once.

// File: rtl/apb_wait_mem_pkg.sv
package apb_wait_mem_pkg;

  // Phase of the transfer being served
  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_WAITING  = 2'd1,
    PH_COMPLETE = 2'd2
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic memWrite;   // store pwdata at the indexed entry
    logic loadRd;     // register the read word onto prdata
    logic clearRd;    // return prdata to zero
  } strobe_t;

endpackage

// File: rtl/apb_wait_mem_ctrl.sv
module apb_wait_mem_ctrl
  import apb_wait_mem_pkg::*;
#(
  parameter int WAIT_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [WAIT_BITS-1:0] cfgWait,
  input  logic                 cfgErr,
  input  logic                 cfgIdleReady,
  output logic                 pready,
  output logic                 pslverr,
  output strobe_t              strobe
);

  localparam logic [WAIT_BITS-1:0] CNT_ONE  = WAIT_BITS'(1);
  localparam logic [WAIT_BITS-1:0] CNT_ZERO = '0;

  phase_t               phase;
  logic [WAIT_BITS-1:0] waitLeft;
  logic                 isWrite;
  logic                 errHeld;
  logic                 errOut;
  logic                 setupSeen;
  logic                 lastWait;

  assign setupSeen = (phase == PH_IDLE) && psel && !penable;
  assign lastWait  = (phase == PH_WAITING) && psel && (waitLeft == CNT_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      waitLeft <= '0;
      isWrite  <= 1'b0;
      errHeld  <= 1'b0;
      errOut   <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (setupSeen) begin
            isWrite  <= pwrite;
            errHeld  <= cfgErr;
            waitLeft <= cfgWait;
            if (cfgWait == CNT_ZERO) begin
              phase  <= PH_COMPLETE;
              errOut <= cfgErr;
            end else begin
              phase  <= PH_WAITING;
            end
          end
        end
        PH_WAITING: begin
          if (!psel) begin
            phase <= PH_IDLE;
          end else if (waitLeft == CNT_ONE) begin
            phase  <= PH_COMPLETE;
            errOut <= errHeld;
          end else begin
            waitLeft <= waitLeft - CNT_ONE;
          end
        end
        PH_COMPLETE: begin
          phase  <= PH_IDLE;
          errOut <= 1'b0;
        end
        default: begin
          phase  <= PH_IDLE;
          errOut <= 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.loadRd   = (setupSeen && !pwrite && (cfgWait == CNT_ZERO)) ||
                      (lastWait && !isWrite);
    strobe.memWrite = (phase == PH_COMPLETE) && isWrite && psel && penable;
    strobe.clearRd  = (phase == PH_COMPLETE) ||
                      ((phase == PH_WAITING) && !psel);
  end

  assign pready  = (phase == PH_IDLE) ? cfgIdleReady : (phase == PH_COMPLETE);
  assign pslverr = errOut;

  AST_WAIT_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (setupSeen && (cfgWait != CNT_ZERO)) |=> !pready) else $error("wait"); // R4

  AST_ZERO_WAIT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (setupSeen && (cfgWait == CNT_ZERO)) |=> pready) else $error("zero wait"); // R4

  AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rstN)
    pslverr |-> (pready && (phase == PH_COMPLETE))) else $error("err"); // R6

  AST_AFTER_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_COMPLETE) |=> ((pready == cfgIdleReady) && !pslverr)) else $error("after"); // R7

endmodule

// File: rtl/apb_wait_mem_dpath.sv
module apb_wait_mem_dpath
  import apb_wait_mem_pkg::*;
#(
  parameter int          DEPTH       = 16,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] DEFAULT_VAL = 32'h0000_0000,
  localparam int         IDX_W       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] prdata
);

  logic [DATA_W-1:0] entryData  [DEPTH];
  logic [DEPTH-1:0]  entryValid;
  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] rdReg;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit;
    assign hit = strobe.memWrite && (wordIdx == IDX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) entryValid[e] <= 1'b0;
      else if (hit) entryValid[e] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) entryData[e] <= wrData;
    end
  end

  assign rdWord = entryValid[wordIdx] ? entryData[wordIdx] : DATA_W'(DEFAULT_VAL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdReg <= '0;
    else if (strobe.loadRd)  rdReg <= rdWord;
    else if (strobe.clearRd) rdReg <= '0;
  end

  assign prdata = rdReg;

  AST_WRITE_MARKS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strobe.memWrite |=> entryValid[$past(wordIdx)]) else $error("valid"); // R2

  AST_RD_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearRd && !strobe.loadRd) |=> (prdata == '0)) else $error("clear"); // R7

endmodule

// File: rtl/apb_wait_mem.sv
module apb_wait_mem
  import apb_wait_mem_pkg::*;
#(
  parameter int          DEPTH       = 16,
  parameter int          WAIT_BITS   = 4,
  parameter logic [31:0] DEFAULT_VAL = 32'h0000_0000,
  localparam int         ADDR_BITS   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [31:0]          paddr,
  input  logic [31:0]          pwdata,
  input  logic [WAIT_BITS-1:0] cfgWait,
  input  logic                 cfgErr,
  input  logic                 cfgIdleReady,
  output logic [31:0]          prdata,
  output logic                 pready,
  output logic                 pslverr
);

  strobe_t              strobe;
  logic [ADDR_BITS-1:0] wordIdx;
  logic                 unusedAddrBits;

  assign wordIdx        = paddr[ADDR_BITS+1:2];
  assign unusedAddrBits = ^{paddr[31:ADDR_BITS+2], paddr[1:0]};

  apb_wait_mem_ctrl #(
    .WAIT_BITS(WAIT_BITS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .cfgWait     (cfgWait),
    .cfgErr      (cfgErr),
    .cfgIdleReady(cfgIdleReady),
    .pready      (pready),
    .pslverr     (pslverr),
    .strobe      (strobe)
  );

  apb_wait_mem_dpath #(
    .DEPTH      (DEPTH),
    .DATA_W     (32),
    .DEFAULT_VAL(DEFAULT_VAL)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wordIdx(wordIdx),
    .wrData (pwdata),
    .prdata (prdata)
  );

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (prdata != '0) |-> pready) else $error("rdata"); // R8

  AST_START_NEEDS_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    (!psel && !pready) |=> (pready == cfgIdleReady)) else $error("start"); // R1

endmodule

// File: tb/apb_wait_mem_bench.sv
module apb_wait_mem_bench;

  localparam int          DEPTH  = 8;
  localparam int          WB     = 4;
  localparam logic [31:0] DEFVAL = 32'hDEAD_BEEF;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0]   paddr = '0, pwdata = '0;
  logic [WB-1:0] cfgWait = '0;
  logic          cfgErr = 1'b0, cfgIdleReady = 1'b0;
  logic [31:0]   prdata;
  logic          pready, pslverr;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  apb_wait_mem #(.DEPTH(DEPTH), .WAIT_BITS(WB), .DEFAULT_VAL(DEFVAL)) u_apb_wait_mem (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .cfgWait(cfgWait), .cfgErr(cfgErr),
    .cfgIdleReady(cfgIdleReady), .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pattern(input int i);
    return 32'h0101_0101 * (i + 3) ^ (32'(i) << 20);
  endfunction

  // Called at a falling edge with the bus idle; returns at a falling edge with the bus idle
  task automatic xfer(input logic wr, input logic [31:0] addr, input logic [31:0] wdata,
                      input int waitN, input logic err, input logic [31:0] expRd);
    int cnt;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = wdata;
    cfgWait = WB'(waitN); cfgErr = err;
    @(negedge clk);
    penable = 1'b1;
    cfgWait = ~cfgWait;   // R5: changes after setup must be ignored
    cfgErr  = ~err;
    cnt = 0;
    while (pready !== 1'b1 && cnt < 40) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == waitN, "R4 wait cycles (R5 sampled once)", 32'(cnt), 32'(waitN));
    chk(pslverr === err, "R6 pslverr at completion (R5)", {31'b0, pslverr}, {31'b0, err});
    if (wr) chk(prdata === 32'h0, "R6 prdata zero on write", prdata, 32'h0);
    else    chk(prdata === expRd, "R3 R6 read word", prdata, expRd);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    chk(pready === cfgIdleReady && pslverr === 1'b0 && prdata === 32'h0,
        "R7 after completion", {prdata[29:0], pready, pslverr}, {30'b0, cfgIdleReady, 1'b0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1;
    chk(pready === 1'b0 && pslverr === 1'b0 && prdata === 32'h0, "R9 reset state",
        {prdata[29:0], pready, pslverr}, 32'h0);
    cfgIdleReady = 1'b1; #1;
    chk(pready === 1'b1, "R9 R8 idle level during reset", {31'b0, pready}, 32'h1);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8: idle outputs under both idle levels
    for (int lvl = 0; lvl < 2; lvl++) begin
      cfgIdleReady = lvl[0];
      @(negedge clk);
      chk(pready === lvl[0] && pslverr === 1'b0 && prdata === 32'h0, "R8 idle outputs",
          {prdata[29:0], pready, pslverr}, {30'b0, lvl[0], 1'b0});
    end

    // R3: every entry reads the default before any write
    for (int i = 0; i < DEPTH; i++) xfer(1'b0, 32'(i * 4), 32'h0, i % 3, 1'b0, DEFVAL);

    // R1 R2 R4 R6: write every entry, sweeping waits, errors and idle levels
    for (int i = 0; i < DEPTH; i++) begin
      cfgIdleReady = (i >= DEPTH / 2);
      xfer(1'b1, 32'(i * 4), pattern(i), i % 4, i[0], 32'h0);
    end

    // R3: read back with a different sweep
    for (int i = 0; i < DEPTH; i++) begin
      cfgIdleReady = i[1];
      xfer(1'b0, 32'(i * 4), 32'h0, (i + 1) % 5, ~i[0], pattern(i));
    end

    // R2: upper and low address bits are ignored (aliasing)
    for (int i = 0; i < DEPTH; i++)
      xfer(1'b0, 32'(i * 4 + DEPTH * 4 * (i + 1) + (i % 4)), 32'h0, 0, 1'b0, pattern(i));
    xfer(1'b1, 32'(2 * 4 + DEPTH * 4 * 5), 32'hCAFE_0002, 2, 1'b0, 32'h0);
    xfer(1'b0, 32'(2 * 4), 32'h0, 1, 1'b0, 32'hCAFE_0002);
    xfer(1'b0, 32'(3 * 4), 32'h0, 0, 1'b0, pattern(3));

    // R1: a write line change after setup does not turn a read into a write
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 32'(5 * 4); cfgWait = 4'd1; cfgErr = 1'b0;
    pwdata = 32'h5555_AAAA;
    @(negedge clk);
    penable = 1'b1; pwrite = 1'b1;
    @(negedge clk);
    chk(pready === 1'b1 && prdata === pattern(5), "R1 read decided at setup", prdata, pattern(5));
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    xfer(1'b0, 32'(5 * 4), 32'h0, 0, 1'b0, pattern(5));

    // R9: reset inside a completing cycle
    cfgIdleReady = 1'b0;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 32'(6 * 4); cfgWait = 4'd2; cfgErr = 1'b1;
    @(negedge clk);
    penable = 1'b1;
    repeat (2) @(negedge clk);
    chk(pready === 1'b1 && pslverr === 1'b1 && prdata === pattern(6), "R9 pre-reset completion",
        prdata, pattern(6));
    #2 rstN = 1'b0;
    #1;
    chk(pready === 1'b0 && pslverr === 1'b0 && prdata === 32'h0, "R9 async reset mid-completion",
        {prdata[29:0], pready, pslverr}, 32'h0);
    psel = 1'b0; penable = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) xfer(1'b0, 32'(i * 4), 32'h0, 0, 1'b0, DEFVAL);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule